// File: doc/BRIEF.md
# Display Mode Line Sanitizer

The sanitizer accepts a requested display mode line (four horizontal values and four vertical values, each 16 bits wide, counted from the start of the line or frame) and returns a mode line that a character-cell timing generator with narrow counter and sync-width registers can be programmed with directly. The corrections form a fixed chain, and each step works on the values that the earlier steps have already adjusted. The horizontal axis first snaps its values to whole 8-pixel character cells. Both axes are then limited to their register ranges. After that, display end is kept within a sensible band, the total is placed inside a legal blanking window, the sync pulse is moved into blanking, and the pulse width is cut to what the sync-width field can hold.

Inputs arrive on a valid/ready handshake. One datapath, instantiated once per axis with different parameters, computes the corrected line in a single combinational pass, and an output register captures it. A two-state controller manages that register. In S_EMPTY the register holds nothing. ACCEPT (valid input) moves the controller to S_FULL. From S_FULL, DRAIN (output taken, no new input) returns it to S_EMPTY. REFILL (output taken and new input accepted in the same cycle) keeps it in S_FULL. STALL (output not taken) also keeps it in S_FULL and freezes the output register.

Top module: `mlsan_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The horizontal outputs (display end, sync start, sync end, total) always have their three low bits equal to zero. The input values are rounded down to a multiple of 8 before any other step.
- R3: Before the other corrections, the register-range limits apply. Horizontal limits: display end ≤ 4072, sync start ≤ 4080, sync end ≤ 4088, total ≤ 4128. Vertical limits: display end ≤ 2045, sync start ≤ 2046, sync end ≤ 2047, total ≤ 2049.
- R4: Horizontal display end is then forced into the range 640 to 2048.
- R5: Horizontal total is raised to at least display end + 80. It is then lowered to at most display end + 1016.
- R6: Horizontal sync end is capped at total − 8. Sync start is then raised to at least display end + 8. Sync end is then capped at sync start + 248.
- R7: Vertical display end is forced into the range 480 to 1536.
- R8: Vertical total is raised to at least display end + 3. It is then lowered to at most display end + 255.
- R9: Vertical sync end is capped at total − 1. Sync start is then raised to at least display end + 1. Sync end is then capped at sync start + 15.
- R10: out_valid is 1 in the cycle after an input is accepted (in_valid and in_ready both high at a clock edge). While out_valid is 1 and out_ready is 0, out_valid and all eight output fields hold.
- R11: While out_valid is 1 and out_ready is 0, in_ready is 0. Whenever out_ready is 1, in_ready is 1, so back-to-back inputs are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Requested mode line present |
| in_ready | output | 1 | Request accepted at this edge if in_valid |
| in_hdisp | input | 16 | Requested horizontal display end |
| in_hsstart | input | 16 | Requested horizontal sync start |
| in_hsend | input | 16 | Requested horizontal sync end |
| in_htotal | input | 16 | Requested horizontal total |
| in_vdisp | input | 16 | Requested vertical display end |
| in_vsstart | input | 16 | Requested vertical sync start |
| in_vsend | input | 16 | Requested vertical sync end |
| in_vtotal | input | 16 | Requested vertical total |
| out_valid | output | 1 | Corrected mode line present |
| out_ready | input | 1 | Consumer takes the corrected line |
| out_hdisp | output | 16 | Corrected horizontal display end |
| out_hsstart | output | 16 | Corrected horizontal sync start |
| out_hsend | output | 16 | Corrected horizontal sync end |
| out_htotal | output | 16 | Corrected horizontal total |
| out_vdisp | output | 16 | Corrected vertical display end |
| out_vsstart | output | 16 | Corrected vertical sync start |
| out_vsend | output | 16 | Corrected vertical sync end |
| out_vtotal | output | 16 | Corrected vertical total |

## Verification
The value assertions assume that any 16-bit input produces no overflow in the chain. This holds because every sum is formed only after the range and display clamps, and those clamps bound each operand far below 2^16. The stimulus therefore uses the whole input space: all-zero, all-ones and out-of-window lines, plus random fields up to 0xFFFF. The handshake assertions assume that in_valid, once raised, stays high until the line is accepted. The driver meets this by holding its data until it observes in_ready high before a clock edge.

// File: rtl/mlsan_pkg.sv
package mlsan_pkg;
    localparam int unsigned FIELD_W = 16;

    typedef struct packed {
        logic [FIELD_W-1:0] disp;
        logic [FIELD_W-1:0] sstart;
        logic [FIELD_W-1:0] send;
        logic [FIELD_W-1:0] total;
    } axis_t;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_FULL  = 1'b1
    } slot_state_t;
endpackage

// File: rtl/mlsan_axis.sv
module mlsan_axis
    import mlsan_pkg::*;
#(
    parameter int unsigned GRAIN     = 3,
    parameter int unsigned CODE_MAX  = 'h1FF,
    parameter int unsigned TOT_EXTRA = 5,
    parameter int unsigned DISP_MIN  = 640,
    parameter int unsigned DISP_MAX  = 2048,
    parameter int unsigned BLANK_MIN = 80,
    parameter int unsigned BLANK_MAX = 'h3F8,
    parameter int unsigned EDGE      = 8,
    parameter int unsigned SYNC_MAX  = 'hF8
) (
    input  axis_t req,
    output axis_t fix
);
    localparam int unsigned W = FIELD_W;
    localparam logic [W-1:0] CELL_MASK = ~W'((1 << GRAIN) - 1);
    localparam logic [W-1:0] LIM_DISP  = W'((CODE_MAX - 2) << GRAIN);
    localparam logic [W-1:0] LIM_SS    = W'((CODE_MAX - 1) << GRAIN);
    localparam logic [W-1:0] LIM_SE    = W'(CODE_MAX << GRAIN);
    localparam logic [W-1:0] LIM_TOT   = W'((CODE_MAX + TOT_EXTRA) << GRAIN);
    localparam logic [W-1:0] K_DMIN    = W'(DISP_MIN);
    localparam logic [W-1:0] K_DMAX    = W'(DISP_MAX);
    localparam logic [W-1:0] K_BMIN    = W'(BLANK_MIN);
    localparam logic [W-1:0] K_BMAX    = W'(BLANK_MAX);
    localparam logic [W-1:0] K_EDGE    = W'(EDGE);
    localparam logic [W-1:0] K_SYNC    = W'(SYNC_MAX);

    logic [W-1:0] d, s, e, t;

    // Ordered chain: each step sees the results of the steps above it.
    always_comb begin
        d = req.disp   & CELL_MASK;
        s = req.sstart & CELL_MASK;
        e = req.send   & CELL_MASK;
        t = req.total  & CELL_MASK;
        if (d > LIM_DISP) d = LIM_DISP;
        if (s > LIM_SS)   s = LIM_SS;
        if (e > LIM_SE)   e = LIM_SE;
        if (t > LIM_TOT)  t = LIM_TOT;
        if (d < K_DMIN)   d = K_DMIN;
        if (d > K_DMAX)   d = K_DMAX;
        if (t < d + K_BMIN) t = d + K_BMIN;
        if (t > d + K_BMAX) t = d + K_BMAX;
        if (e > t - K_EDGE) e = t - K_EDGE;
        if (s < d + K_EDGE) s = d + K_EDGE;
        if (e > s + K_SYNC) e = s + K_SYNC;
    end

    assign fix = '{disp: d, sstart: s, send: e, total: t};
endmodule

// File: rtl/mlsan_ctrl.sv
module mlsan_ctrl
    import mlsan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    slot_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            S_EMPTY: nxt = in_valid ? S_FULL : S_EMPTY;             // ACCEPT
            S_FULL:  nxt = (out_ready && !in_valid) ? S_EMPTY : S_FULL; // DRAIN / REFILL / STALL
            default: nxt = S_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state == S_FULL);
        in_ready  = (state == S_EMPTY) || out_ready;
        load      = in_valid && in_ready;
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
    assert_backpress_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    assert_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
endmodule

// File: rtl/mlsan_top.sv
module mlsan_top
    import mlsan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [FIELD_W-1:0]  in_hdisp,
    input  logic [FIELD_W-1:0]  in_hsstart,
    input  logic [FIELD_W-1:0]  in_hsend,
    input  logic [FIELD_W-1:0]  in_htotal,
    input  logic [FIELD_W-1:0]  in_vdisp,
    input  logic [FIELD_W-1:0]  in_vsstart,
    input  logic [FIELD_W-1:0]  in_vsend,
    input  logic [FIELD_W-1:0]  in_vtotal,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [FIELD_W-1:0]  out_hdisp,
    output logic [FIELD_W-1:0]  out_hsstart,
    output logic [FIELD_W-1:0]  out_hsend,
    output logic [FIELD_W-1:0]  out_htotal,
    output logic [FIELD_W-1:0]  out_vdisp,
    output logic [FIELD_W-1:0]  out_vsstart,
    output logic [FIELD_W-1:0]  out_vsend,
    output logic [FIELD_W-1:0]  out_vtotal
);
    axis_t h_req, v_req, h_fix, v_fix, h_q, v_q;
    logic  load;

    assign h_req = '{disp: in_hdisp, sstart: in_hsstart, send: in_hsend, total: in_htotal};
    assign v_req = '{disp: in_vdisp, sstart: in_vsstart, send: in_vsend, total: in_vtotal};

    mlsan_axis #(
        .GRAIN(3), .CODE_MAX('h1FF), .TOT_EXTRA(5), .DISP_MIN(640), .DISP_MAX(2048),
        .BLANK_MIN(80), .BLANK_MAX('h3F8), .EDGE(8), .SYNC_MAX('hF8)
    ) u_h (.req(h_req), .fix(h_fix));

    mlsan_axis #(
        .GRAIN(0), .CODE_MAX('h7FF), .TOT_EXTRA(2), .DISP_MIN(480), .DISP_MAX(1536),
        .BLANK_MIN(3), .BLANK_MAX('hFF), .EDGE(1), .SYNC_MAX('h0F)
    ) u_v (.req(v_req), .fix(v_fix));

    mlsan_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .load(load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (load) begin
            h_q <= h_fix;
            v_q <= v_fix;
        end
    end

    assign out_hdisp   = h_q.disp;
    assign out_hsstart = h_q.sstart;
    assign out_hsend   = h_q.send;
    assign out_htotal  = h_q.total;
    assign out_vdisp   = v_q.disp;
    assign out_vsstart = v_q.sstart;
    assign out_vsend   = v_q.send;
    assign out_vtotal  = v_q.total;

    assert_hgrain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hdisp[2:0] == 3'd0 && out_hsstart[2:0] == 3'd0 &&
                       out_hsend[2:0] == 3'd0 && out_htotal[2:0] == 3'd0));
    assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hsstart <= 16'd4080 && out_hsend <= 16'd4088 &&
                       out_htotal <= 16'd4128 && out_vsstart <= 16'd2046 &&
                       out_vsend <= 16'd2047 && out_vtotal <= 16'd2049));
    assert_hdisp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hdisp >= 16'd640 && out_hdisp <= 16'd2048));
    assert_htot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_htotal >= out_hdisp + 16'd80 && out_htotal <= out_hdisp + 16'd1016));
    assert_hsync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hsend <= out_htotal - 16'd8 && out_hsstart >= out_hdisp + 16'd8 &&
                       out_hsend <= out_hsstart + 16'd248));
    assert_vdisp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vdisp >= 16'd480 && out_vdisp <= 16'd1536));
    assert_vtot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vtotal >= out_vdisp + 16'd3 && out_vtotal <= out_vdisp + 16'd255));
    assert_vsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vsend <= out_vtotal - 16'd1 && out_vsstart >= out_vdisp + 16'd1 &&
                       out_vsend <= out_vsstart + 16'd15));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_hdisp) && $stable(out_hsstart) &&
            $stable(out_hsend) && $stable(out_htotal) && $stable(out_vdisp) &&
            $stable(out_vsstart) && $stable(out_vsend) && $stable(out_vtotal)));
endmodule

// File: tb/sim_mlsan_top.sv
module sim_mlsan_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic clk, rst_n, in_valid, in_ready, out_valid, out_ready;
    logic [15:0] in_hdisp, in_hsstart, in_hsend, in_htotal;
    logic [15:0] in_vdisp, in_vsstart, in_vsend, in_vtotal;
    logic [15:0] out_hdisp, out_hsstart, out_hsend, out_htotal;
    logic [15:0] out_vdisp, out_vsstart, out_vsend, out_vtotal;

    mlsan_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdisp(in_hdisp), .in_hsstart(in_hsstart), .in_hsend(in_hsend), .in_htotal(in_htotal),
        .in_vdisp(in_vdisp), .in_vsstart(in_vsstart), .in_vsend(in_vsend), .in_vtotal(in_vtotal),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_hdisp(out_hdisp), .out_hsstart(out_hsstart), .out_hsend(out_hsend),
        .out_htotal(out_htotal), .out_vdisp(out_vdisp), .out_vsstart(out_vsstart),
        .out_vsend(out_vsend), .out_vtotal(out_vtotal)
    );

    int checks = 0, errors = 0;
    logic [127:0] expq[$];
    string tagq[$];
    bit just_acc = 0, stall_mode = 0, held = 0;
    logic [127:0] held_data;
    string fld_name[8] = '{"hdisp", "hsstart", "hsend", "htotal", "vdisp", "vsstart", "vsend", "vtotal"};
    string fld_req[8]  = '{"R4", "R6", "R6", "R5", "R7", "R9", "R9", "R8"};

    initial clk = 0;
    always #(HALF) clk = ~clk;

    function automatic logic [127:0] out_bus();
        return {out_hdisp, out_hsstart, out_hsend, out_htotal,
                out_vdisp, out_vsstart, out_vsend, out_vtotal};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent model of the correction chain, written from the requirements.
    function automatic logic [127:0] model(int hd, int hs, int he, int ht,
                                           int vd, int vs, int ve, int vt);
        hd &= ~7; hs &= ~7; he &= ~7; ht &= ~7;
        if (hd > 4072) hd = 4072;
        if (hs > 4080) hs = 4080;
        if (he > 4088) he = 4088;
        if (ht > 4128) ht = 4128;
        if (hd < 640) hd = 640;
        if (hd > 2048) hd = 2048;
        if (ht < hd + 80) ht = hd + 80;
        if (ht > hd + 1016) ht = hd + 1016;
        if (he > ht - 8) he = ht - 8;
        if (hs < hd + 8) hs = hd + 8;
        if (he > hs + 248) he = hs + 248;
        if (vd > 2045) vd = 2045;
        if (vs > 2046) vs = 2046;
        if (ve > 2047) ve = 2047;
        if (vt > 2049) vt = 2049;
        if (vd < 480) vd = 480;
        if (vd > 1536) vd = 1536;
        if (vt < vd + 3) vt = vd + 3;
        if (vt > vd + 255) vt = vd + 255;
        if (ve > vt - 1) ve = vt - 1;
        if (vs < vd + 1) vs = vd + 1;
        if (ve > vs + 15) ve = vs + 15;
        return {16'(hd), 16'(hs), 16'(he), 16'(ht), 16'(vd), 16'(vs), 16'(ve), 16'(vt)};
    endfunction

    task automatic send(input string tag, input int hd, input int hs, input int he, input int ht,
                        input int vd, input int vs, input int ve, input int vt);
        bit got;
        @(negedge clk);
        in_valid = 1;
        in_hdisp = 16'(hd); in_hsstart = 16'(hs); in_hsend = 16'(he); in_htotal = 16'(ht);
        in_vdisp = 16'(vd); in_vsstart = 16'(vs); in_vsend = 16'(ve); in_vtotal = 16'(vt);
        forever begin
            #(HALF - 1);
            got = in_ready;
            @(posedge clk);
            if (got) break;
            @(negedge clk);
        end
        expq.push_back(model(hd, hs, he, ht, vd, vs, ve, vt));
        tagq.push_back(tag);
        just_acc = 1;
    endtask

    // Monitor / scoreboard
    initial begin
        out_ready = 0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
            #(HALF - 1);
            if (just_acc) begin
                check(out_valid == 1'b1, "R10", "out_valid one cycle after accept", out_valid, 1);
                just_acc = 0;
            end
            if (held) begin
                check(out_valid == 1'b1, "R10", "out_valid held under stall", out_valid, 1);
                check(out_bus() == held_data, "R10", "output fields held under stall",
                      longint'(out_bus() ^ held_data), 0);
                held = 0;
            end
            if (out_ready)
                check(in_ready == 1'b1, "R11", "in_ready while out_ready", in_ready, 1);
            if (out_valid && !out_ready) begin
                check(in_ready == 1'b0, "R11", "in_ready during stall", in_ready, 0);
                held = 1;
                held_data = out_bus();
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(0, "R10", "unexpected output line", 1, 0);
                end else begin
                    logic [127:0] exp_v;
                    logic [127:0] act_v;
                    string tag;
                    exp_v = expq.pop_front();
                    tag = tagq.pop_front();
                    act_v = out_bus();
                    for (int i = 0; i < 8; i++) begin
                        check(act_v[127-16*i -: 16] == exp_v[127-16*i -: 16], fld_req[i],
                              $sformatf("%s %s", tag, fld_name[i]),
                              act_v[127-16*i -: 16], exp_v[127-16*i -: 16]);
                    end
                    check(act_v[98:96] == 3'd0 && act_v[114:112] == 3'd0 && act_v[82:80] == 3'd0
                          && act_v[127-:16] % 8 == 0, "R2", $sformatf("%s horizontal grain", tag),
                          act_v[127-:16] % 8, 0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run hung actual=%0d expected=%0d", expq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0;
        in_hdisp = 0; in_hsstart = 0; in_hsend = 0; in_htotal = 0;
        in_vdisp = 0; in_vsstart = 0; in_vsend = 0; in_vtotal = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #(HALF - 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        send("R2 odd", 1027, 1053, 1190, 1351, 768, 771, 777, 806);
        send("R4 zero", 0, 0, 0, 0, 0, 0, 0, 0);
        send("R3 ones", 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF);
        send("R5 short", 1024, 1032, 1040, 1050, 600, 601, 602, 603);
        send("R5 long", 640, 700, 800, 3000, 480, 490, 495, 1000);
        send("R6 wide", 1024, 1100, 1500, 2000, 768, 771, 777, 806);
        send("R6 edge", 1024, 900, 1400, 1300, 768, 771, 777, 806);
        send("R7 tall", 2000, 2100, 2200, 2400, 2000, 2010, 2020, 2040);
        send("R8 long", 800, 840, 960, 1056, 600, 601, 605, 1200);
        send("R9 wide", 800, 840, 960, 1056, 768, 800, 900, 1000);
        send("R9 edge", 800, 840, 960, 1056, 768, 700, 1100, 780);

        stall_mode = 1;
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0)
                send("R3 rnd", $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
                     $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
                     $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
                     $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF));
            else
                send("R6 rnd", $urandom_range(0, 4200), $urandom_range(0, 4200),
                     $urandom_range(0, 4200), $urandom_range(0, 4200),
                     $urandom_range(0, 2200), $urandom_range(0, 2200),
                     $urandom_range(0, 2200), $urandom_range(0, 2200));
            if (i == 200) stall_mode = 0;
        end
        @(negedge clk);
        in_valid = 0;
        stall_mode = 0;
        wait (expq.size() == 0);
        repeat (3) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule